// File: doc/BRIEF.md
# Maskable Interrupt Entry Sequencer

This block handles maskable interrupts for a small 8-bit processor core. The request line is active low and level sensitive, so several sources can share it as a wired-AND. The block looks at the line only when the core marks an instruction boundary. If the line is low at that moment and the interrupt-disable flag is clear, the block runs an entry sequence instead of letting the core fetch its next opcode. While the sequence runs, `busy` is held high so that the core stalls.

The entry sequence works as follows:
- The first cycles are internal and make no bus access.
- The block then pushes the program counter and a status byte onto a descending stack in a fixed stack page.
- It sets the disable flag.
- It reads a two-byte vector.
- In the final cycle it hands the core a new program counter and a new stack pointer.

The core's dedicated set-disable and clear-disable instructions reach the block as single-cycle strobes. The block owns the disable flag.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `mem_we`, `mem_re`, `pc_wr_en` and `sp_wr_en` are 0 and `i_flag` is 1.
- R2: Entry starts on the clock edge where `boundary` is 1, `irq_n` is 0, `i_flag` is 0 and `busy` is 0. Under any other condition `busy` stays 0.
- R3: `irq_n` is examined only while `boundary` is 1. A low level or a low pulse that lies entirely between boundaries does not start an entry.
- R4: `sei_stb` sets `i_flag` and `cli_stb` clears it, effective on the next clock edge. If both are asserted together, set wins.
- R5: With the defaults, entry keeps `busy` high for exactly 7 cycles. The first 2 cycles have neither `mem_we` nor `mem_re` asserted. `mem_we` and `mem_re` are never both high.
- R6: Cycles 3, 4 and 5 write the PC high byte, then the PC low byte, then the status byte. The addresses are {0x01, SP}, {0x01, SP-1} and {0x01, SP-2}, where SP is `sp_cur` at the start edge. The low address byte wraps within the page.
- R7: The pushed status byte takes bits 7, 6, 3, 1 and 0 from `flags_cur`. Bit 5 is 1, bit 4 (break) is 0, and bit 2 (disable) is 0.
- R8: `i_flag` becomes 1 at the edge that ends the status push. It is 1 from cycle 6 onward.
- R9: Cycles 6 and 7 read address 0xFFFE (low byte) and then 0xFFFF (high byte). In cycle 7, `pc_wr_en` and `sp_wr_en` are 1, `pc_next` is {high, low} and `sp_next` is SP-3.
- R10: `boundary` is ignored while `busy` is 1. If `irq_n` is still low and the flag is later cleared, the next boundary starts a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Shared interrupt request, active low, level |
| boundary | input | 1 | Core is at an instruction boundary |
| sei_stb | input | 1 | Set-disable instruction strobe |
| cli_stb | input | 1 | Clear-disable instruction strobe |
| pc_cur | input | 16 | Program counter of the core |
| sp_cur | input | 8 | Stack pointer of the core |
| flags_cur | input | 8 | Status flags of the core |
| mem_rdata | input | 8 | Read data, valid in the cycle of the access |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| pc_wr_en | output | 1 | Load `pc_next` into the core |
| pc_next | output | 16 | Vector target |
| sp_wr_en | output | 1 | Load `sp_next` into the core |
| sp_next | output | 8 | Stack pointer after three pushes |
| i_flag | output | 1 | Interrupt-disable flag |
| busy | output | 1 | Entry in progress; the core stalls |

## Verification
The bench uses the default parameters: two internal cycles, stack page 0x01 and the vector at 0xFFFE. With the vector at the top of the address space, the high-byte read lands on the all-ones address. With an 8-bit stack pointer, the push wraparound can be reached by starting with SP at 0x01 or 0x00. Random passes vary the PC, SP, flags, vector bytes, request level and flag state. Directed cases cover four situations: a request pulse that falls between boundaries, a boundary held high during an entry, a request that stays low across a set flag followed by a clear, and simultaneous set and clear strobes.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          INT_CYCLES = 2,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VECTOR_LO  = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_n,
  input  logic        boundary,
  input  logic        sei_stb,
  input  logic        cli_stb,
  input  logic [15:0] pc_cur,
  input  logic [7:0]  sp_cur,
  input  logic [7:0]  flags_cur,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic        pc_wr_en,
  output logic [15:0] pc_next,
  output logic        sp_wr_en,
  output logic [7:0]  sp_next,
  output logic        i_flag,
  output logic        busy
);
  localparam int LAST = INT_CYCLES + 4;
  localparam int CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] P_PCH = CW'(INT_CYCLES);
  localparam logic [CW-1:0] P_PCL = CW'(INT_CYCLES + 1);
  localparam logic [CW-1:0] P_ST  = CW'(INT_CYCLES + 2);
  localparam logic [CW-1:0] P_VL  = CW'(INT_CYCLES + 3);
  localparam logic [CW-1:0] P_VH  = CW'(LAST);

  logic [CW-1:0] phase;
  logic [15:0]   pc_q;
  logic [7:0]    sp_q, flags_q, vlo_q;
  logic          i_q, busy_q;

  wire start    = !busy_q && boundary && !irq_n && !i_q;
  wire in_push  = busy_q && phase >= P_PCH && phase <= P_ST;
  wire in_read  = busy_q && (phase == P_VL || phase == P_VH);
  wire [7:0] status_img = (flags_q & 8'hCB) | 8'h20 | {5'b0, i_q, 2'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase   <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      flags_q <= '0;
      vlo_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      phase   <= '0;
      pc_q    <= pc_cur;
      sp_q    <= sp_cur;
      flags_q <= flags_cur;
    end else if (busy_q) begin
      if (phase == P_VH) busy_q <= 1'b0;
      else               phase  <= phase + 1'b1;
      if (phase == P_VL) vlo_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         i_q <= 1'b1;
    else if (busy_q && phase == P_ST)   i_q <= 1'b1;
    else if (sei_stb)                   i_q <= 1'b1;
    else if (cli_stb)                   i_q <= 1'b0;
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    if (in_push) begin
      mem_addr = {STACK_PAGE, sp_q - 8'(phase - P_PCH)};
      case (phase)
        P_PCH:   mem_wdata = pc_q[15:8];
        P_PCL:   mem_wdata = pc_q[7:0];
        default: mem_wdata = status_img;
      endcase
    end else if (in_read) begin
      mem_addr = (phase == P_VL) ? VECTOR_LO : VECTOR_LO + 16'd1;
    end
  end

  assign mem_we   = in_push;
  assign mem_re   = in_read;
  assign pc_wr_en = busy_q && phase == P_VH;
  assign pc_next  = {mem_rdata, vlo_q};
  assign sp_wr_en = pc_wr_en;
  assign sp_next  = sp_q - 8'd3;
  assign i_flag   = i_q;
  assign busy     = busy_q;

  // R2
  take_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && boundary && !irq_n && !i_flag) |=> busy);
  // R2
  no_take_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && boundary && (irq_n || i_flag)) |=> !busy);
  // R3
  no_take_off_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !boundary) |=> !busy);
  // R5
  idle_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!mem_we && !mem_re));
  // R5
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R8
  masked_at_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |-> i_flag);
  // R9
  low_byte_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |-> ($past(mem_re) && $past(mem_addr) == VECTOR_LO));
  // R9
  done_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> !busy);
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic clk = 0, rst_n = 0, irq_n = 1, boundary = 0, sei_stb = 0, cli_stb = 0;
  logic [15:0] pc_cur = 0;
  logic [7:0]  sp_cur = 8'hFD, flags_cur = 0, vlo = 0, vhi = 0;
  logic [7:0]  mem_rdata, mem_wdata, sp_next;
  logic [15:0] mem_addr, pc_next;
  logic mem_we, mem_re, pc_wr_en, sp_wr_en, i_flag, busy;
  int checks = 0, errors = 0;
  bit i_model = 1, done = 0;

  always #5 clk = ~clk;

  assign mem_rdata = (mem_addr == 16'hFFFE) ? vlo : (mem_addr == 16'hFFFF) ? vhi : 8'h00;

  irq_entry_seq u_dut (.clk, .rst_n, .irq_n, .boundary, .sei_stb, .cli_stb,
    .pc_cur, .sp_cur, .flags_cur, .mem_rdata, .mem_addr, .mem_wdata, .mem_we,
    .mem_re, .pc_wr_en, .pc_next, .sp_wr_en, .sp_next, .i_flag, .busy);

  function automatic logic [7:0] exp_status(logic [7:0] f);
    return {f[7:6], 2'b10, f[3], 1'b0, f[1:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_flag(input bit s, input bit c);
    @(negedge clk); sei_stb = s; cli_stb = c;
    @(negedge clk); sei_stb = 0; cli_stb = 0;
    if (s) i_model = 1; else if (c) i_model = 0;
    chk(i_flag == i_model, "R4 i_flag", i_flag, i_model);
  endtask

  task automatic check_cycle(input int k);
    logic [7:0] sp = sp_cur;
    chk(busy == 1, $sformatf("R5 busy k%0d", k), busy, 1);
    chk(!(mem_we && mem_re), "R5 exclusive", {mem_we, mem_re}, 0);
    case (k)
      0, 1: chk(!mem_we && !mem_re, "R5 idle", {mem_we, mem_re}, 0);
      2: chk(mem_we && mem_addr == {8'h01, sp} && mem_wdata == pc_cur[15:8],
             "R6 pch", {mem_we, mem_addr, mem_wdata}, {1'b1, 8'h01, sp, pc_cur[15:8]});
      3: chk(mem_we && mem_addr == {8'h01, 8'(sp - 1)} && mem_wdata == pc_cur[7:0],
             "R6 pcl", {mem_we, mem_addr, mem_wdata}, {1'b1, 8'h01, 8'(sp - 1), pc_cur[7:0]});
      4: begin
           chk(mem_we && mem_addr == {8'h01, 8'(sp - 2)}, "R6 status addr",
               {mem_we, mem_addr}, {1'b1, 8'h01, 8'(sp - 2)});
           chk(mem_wdata == exp_status(flags_cur), "R7 status", mem_wdata, exp_status(flags_cur));
         end
      5: chk(mem_re && !mem_we && mem_addr == 16'hFFFE, "R9 low read", {mem_re, mem_addr}, {1'b1, 16'hFFFE});
      6: begin
           chk(mem_re && mem_addr == 16'hFFFF, "R9 high read", {mem_re, mem_addr}, {1'b1, 16'hFFFF});
           chk(pc_wr_en && pc_next == {vhi, vlo}, "R9 pc", {pc_wr_en, pc_next}, {1'b1, vhi, vlo});
           chk(sp_wr_en && sp_next == 8'(sp - 3), "R9 sp", {sp_wr_en, sp_next}, {1'b1, 8'(sp - 3)});
         end
      default: ;
    endcase
    if (k < 5) chk(i_flag == 0, "R8 flag clear", i_flag, 0);
    else       chk(i_flag == 1, "R8 flag set", i_flag, 1);
    if (k < 6) chk(!pc_wr_en && !sp_wr_en, "R9 early load", {pc_wr_en, sp_wr_en}, 0);
  endtask

  task automatic try_boundary(input logic irq, input bit hold);
    bit take;
    @(negedge clk); boundary = 1; irq_n = irq;
    take = !irq && !i_model;
    @(posedge clk); #1;
    chk(busy == take, "R2 take decision", busy, take);
    if (take) begin
      for (int k = 0; k < 7; k++) begin
        if (k > 0) begin @(posedge clk); #1; end
        check_cycle(k);
        if (!hold || k == 3) begin @(negedge clk); boundary = 0; #1; end
      end
      @(posedge clk); #1;
      chk(busy == 0, "R5 end of entry", busy, 0);
      chk(i_flag == 1, "R8 flag after entry", i_flag, 1);
      i_model = 1;
    end
    @(negedge clk); boundary = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(!busy && !mem_we && !mem_re && !pc_wr_en && !sp_wr_en, "R1 idle outputs",
        {busy, mem_we, mem_re, pc_wr_en, sp_wr_en}, 0);
    chk(i_flag == 1, "R1 flag", i_flag, 1);
    @(negedge clk); rst_n = 1;

    // R4: sei, cli, both together
    set_flag(0, 1);
    set_flag(1, 0);
    set_flag(1, 1);
    try_boundary(1'b0, 0);           // R2: masked
    set_flag(0, 1);

    // R3: low pulse between boundaries is missed
    @(negedge clk); irq_n = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R3 low off boundary", busy, 0);
    irq_n = 1;
    try_boundary(1'b1, 0);
    chk(busy == 0, "R3 pulse missed", busy, 0);

    // R6: stack wrap
    pc_cur = 16'hC3A5; sp_cur = 8'h01; flags_cur = 8'hFF; vlo = 8'h34; vhi = 8'h12;
    try_boundary(1'b0, 0);

    // R10: boundary held during entry, then level re-entry
    set_flag(0, 1);
    pc_cur = 16'h8001; sp_cur = 8'h00; flags_cur = 8'h00; vlo = 8'hEE; vhi = 8'h9A;
    try_boundary(1'b0, 1);
    try_boundary(1'b0, 0);           // R10: flag set, still low, no entry
    chk(busy == 0, "R10 masked while low", busy, 0);
    set_flag(0, 1);
    try_boundary(1'b0, 0);           // R10: re-entry

    for (int n = 0; n < 60; n++) begin
      pc_cur = 16'($urandom); sp_cur = 8'($urandom); flags_cur = 8'($urandom);
      vlo = 8'($urandom); vhi = 8'($urandom);
      if ($urandom % 3 != 0) set_flag(0, 1);
      try_boundary(1'($urandom % 4 == 0), 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule